// File: doc/BRIEF.md
# Differential Jitter Measurement Unit

This block runs a campaign of timing trials on a pair of matched free-running ring oscillators. It is used to characterise a device's jitter. Each trial starts both oscillators in the same cycle and keeps them running for a short, programmed number of clock cycles. It then stops them and raises a one-cycle capture strobe. On that strobe, the two tapped delay lines present their thermometer-coded snapshots to the block. Each snapshot is reduced to the tap index of its first level change. The signed difference between the two indices is the accumulated relative jitter of that trial.

The unit builds two running statistics over the valid trials: the signed sum of the differences and the sum of their squares. A host can derive the mean and the standard deviation from these two values after the campaign. A trial in which either snapshot shows no level change is discarded and repeated. Between trials both oscillators stay off for a programmed idle gap, so that each trial starts from a settled state. When the number of valid trials reaches the programmed target, the unit pulses `done` and holds its results until the next start.

Top module: `jitter_diff_meter`

## Requirements
- R1: A `start` pulse is accepted only while the unit is idle (`busy` low and `done` low). It latches `win_cycles`, `gap_cycles` and `trial_target`, and clears `valid_trials`, `diff_sum` and `diff_sq_sum` to zero. A `start` raised while `busy` is high has no effect on the results.
- R2: In each trial, `osc_en` is high for exactly max(`win_cycles`,1) consecutive cycles.
- R3: `capture` is high for one cycle, in the cycle right after each window closes, and `osc_en` is low in that cycle. `snap_a` and `snap_b` are sampled at the end of that cycle.
- R4: Between two consecutive windows of one campaign, `osc_en` is low for exactly max(`gap_cycles`,1)+2 cycles.
- R5: The edge position of a snapshot is the smallest index j in 1..TAP_W-1 where bit j differs from bit j-1. Either direction of change counts, and all later changes (bubbles or a second edge) are ignored.
- R6: A trial in which either snapshot has all bits equal is invalid. It leaves `valid_trials`, `diff_sum` and `diff_sq_sum` unchanged, and another trial follows.
- R7: For each valid trial, d = pos_a − pos_b is added to `diff_sum` (two's complement) and d² is added to `diff_sq_sum`. Both widths are sized so that 2^TRIAL_W−1 trials cannot overflow them.
- R8: When `valid_trials` reaches the target, `done` is high for exactly one cycle. In that cycle `busy` and `osc_en` are low and the outputs carry the final results.
- R9: After `done`, `valid_trials`, `diff_sum` and `diff_sq_sum` hold their values until the next accepted `start`.
- R10: A `start` with `trial_target` = 0 produces `done` in the next cycle, with zero results and no window.
- R11: During reset and right after it, `osc_en`, `capture`, `busy` and `done` are low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a campaign (accepted while idle) |
| win_cycles | input | WIN_W | Oscillator run window in cycles (0 acts as 1) |
| gap_cycles | input | GAP_W | Idle gap between trials in cycles (0 acts as 1) |
| trial_target | input | TRIAL_W | Number of valid trials to collect |
| snap_a | input | TAP_W | Delay-line snapshot of oscillator A |
| snap_b | input | TAP_W | Delay-line snapshot of oscillator B |
| osc_en | output | 1 | Common enable for both oscillators |
| capture | output | 1 | Strobe telling the delay lines to sample |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | One-cycle pulse at campaign end |
| valid_trials | output | TRIAL_W | Valid trials collected so far |
| diff_sum | output | POS_W+1+TRIAL_W | Signed sum of edge-position differences |
| diff_sq_sum | output | 2*POS_W+TRIAL_W | Sum of squared differences |

## Verification
The hardest situation to reach from the ports is a snapshot whose first change is followed by further changes, combined with invalid trials scattered through a long campaign. In that case a wrong encoder or a miscounted discard still gives plausible-looking statistics. The stimulus answers each `capture` strobe with snapshots computed from a running trial index. Over one campaign this sweeps every pair of edge positions in both polarities, flips the top tap in some trials to add a later change, and feeds a flat snapshot every fifth trial. The expected sums are formed arithmetically from the same index. The bench also times every window and gap, and pokes `start` during a run.

// File: rtl/jdm_pkg.sv
package jdm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WIN,
      ST_SAMP,
      ST_EVAL,
      ST_GAP,
      ST_FIN
   } jdm_state_e;
endpackage

// File: rtl/jdm_edge_locator.sv
// Reduces a thermometer snapshot to the index of its lowest level change.
module jdm_edge_locator #(
   parameter int TAP_W = 16,
   parameter int POS_W = 4
) (
   input  logic [TAP_W-1:0] snap,
   output logic [POS_W-1:0] pos,
   output logic             found
);
   always_comb begin
      pos   = '0;
      found = 1'b0;
      // Scan downward so that the lowest change is the last one written.
      for (int j = TAP_W - 1; j >= 1; j--) begin
         if (snap[j] ^ snap[j-1]) begin
            pos   = POS_W'(j);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/jdm_accum.sv
// Signed sum and sum of squares of per-trial position differences.
module jdm_accum #(
   parameter int POS_W = 4,
   parameter int SUM_W = 15,
   parameter int SQ_W  = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    add,
   input  logic [POS_W-1:0]        pos_a,
   input  logic [POS_W-1:0]        pos_b,
   output logic signed [SUM_W-1:0] sum,
   output logic [SQ_W-1:0]         sq_sum
);
   localparam int D_W = POS_W + 1;

   logic signed [D_W-1:0] diff;
   logic [POS_W-1:0]      mag;
   logic [2*POS_W-1:0]    mag_sq;

   always_comb begin
      diff   = signed'({1'b0, pos_a}) - signed'({1'b0, pos_b});
      mag    = diff[D_W-1] ? POS_W'(-diff) : POS_W'(diff);
      mag_sq = (2*POS_W)'(mag) * (2*POS_W)'(mag);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         sum    <= '0;
         sq_sum <= '0;
      end else if (add) begin
         sum    <= sum + {{(SUM_W-D_W){diff[D_W-1]}}, diff};
         sq_sum <= sq_sum + SQ_W'(mag_sq);
      end
   end
endmodule

// File: rtl/jdm_sequencer.sv
// Trial sequencer: window, capture, evaluate, idle gap, campaign end.
module jdm_sequencer
   import jdm_pkg::*;
#(
   parameter int WIN_W   = 8,
   parameter int GAP_W   = 8,
   parameter int TRIAL_W = 10,
   localparam int CNT_W  = (WIN_W > GAP_W) ? WIN_W : GAP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIN_W-1:0]   win_cycles,
   input  logic [GAP_W-1:0]   gap_cycles,
   input  logic [TRIAL_W-1:0] trial_target,
   input  logic               trial_ok,
   output logic               osc_en,
   output logic               capture,
   output logic               busy,
   output logic               done,
   output logic               clear_acc,
   output logic               eval_en,
   output logic [TRIAL_W-1:0] valid_trials
);
   jdm_state_e         state;
   logic [CNT_W-1:0]   timer;
   logic [WIN_W-1:0]   win_q;
   logic [GAP_W-1:0]   gap_q;
   logic [TRIAL_W-1:0] tgt_q;
   logic [TRIAL_W-1:0] count;
   logic [WIN_W-1:0]   win_eff;
   logic [GAP_W-1:0]   gap_eff;
   logic               win_last;
   logic               gap_last;
   logic               hit_target;

   always_comb begin
      win_eff    = (win_q == '0) ? WIN_W'(1) : win_q;
      gap_eff    = (gap_q == '0) ? GAP_W'(1) : gap_q;
      win_last   = (timer == CNT_W'(win_eff - WIN_W'(1)));
      gap_last   = (timer == CNT_W'(gap_eff - GAP_W'(1)));
      hit_target = trial_ok && ((count + TRIAL_W'(1)) == tgt_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         timer <= '0;
         win_q <= '0;
         gap_q <= '0;
         tgt_q <= '0;
         count <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  win_q <= win_cycles;
                  gap_q <= gap_cycles;
                  tgt_q <= trial_target;
                  count <= '0;
                  timer <= '0;
                  state <= (trial_target == '0) ? ST_FIN : ST_WIN;
               end
            end
            ST_WIN: begin
               if (win_last) begin
                  timer <= '0;
                  state <= ST_SAMP;
               end else begin
                  timer <= timer + CNT_W'(1);
               end
            end
            ST_SAMP: state <= ST_EVAL;
            ST_EVAL: begin
               if (trial_ok) count <= count + TRIAL_W'(1);
               if (hit_target) begin
                  state <= ST_FIN;
               end else begin
                  timer <= '0;
                  state <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (gap_last) begin
                  timer <= '0;
                  state <= ST_WIN;
               end else begin
                  timer <= timer + CNT_W'(1);
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      osc_en       = (state == ST_WIN);
      capture      = (state == ST_SAMP);
      eval_en      = (state == ST_EVAL);
      done         = (state == ST_FIN);
      busy         = (state == ST_WIN) || (state == ST_SAMP) ||
                     (state == ST_EVAL) || (state == ST_GAP);
      clear_acc    = (state == ST_IDLE) && start;
      valid_trials = count;
   end
endmodule

// File: rtl/jitter_diff_meter.sv
// Differential jitter measurement unit: top level.
module jitter_diff_meter #(
   parameter int TAP_W   = 16,
   parameter int WIN_W   = 8,
   parameter int GAP_W   = 8,
   parameter int TRIAL_W = 10,
   localparam int POS_W  = $clog2(TAP_W),
   localparam int SUM_W  = POS_W + 1 + TRIAL_W,
   localparam int SQ_W   = 2 * POS_W + TRIAL_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [WIN_W-1:0]        win_cycles,
   input  logic [GAP_W-1:0]        gap_cycles,
   input  logic [TRIAL_W-1:0]      trial_target,
   input  logic [TAP_W-1:0]        snap_a,
   input  logic [TAP_W-1:0]        snap_b,
   output logic                    osc_en,
   output logic                    capture,
   output logic                    busy,
   output logic                    done,
   output logic [TRIAL_W-1:0]      valid_trials,
   output logic signed [SUM_W-1:0] diff_sum,
   output logic [SQ_W-1:0]         diff_sq_sum
);
   localparam int N_LINES = 2;

   if (TAP_W < 3) begin : g_chk_taps
      $error("jitter_diff_meter: TAP_W must be at least 3");
   end
   if (TRIAL_W < 1 || WIN_W < 1 || GAP_W < 1) begin : g_chk_widths
      $error("jitter_diff_meter: counter widths must be positive");
   end

   logic [TAP_W-1:0] snap_in [N_LINES];
   logic [TAP_W-1:0] snap_q  [N_LINES];
   logic [POS_W-1:0] pos     [N_LINES];
   logic [N_LINES-1:0] found;
   logic clear_acc;
   logic eval_en;
   logic trial_ok;

   assign snap_in[0] = snap_a;
   assign snap_in[1] = snap_b;

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n)       snap_q[i] <= '0;
         else if (capture) snap_q[i] <= snap_in[i];
      end

      jdm_edge_locator #(
         .TAP_W (TAP_W),
         .POS_W (POS_W)
      ) u_loc (
         .snap  (snap_q[i]),
         .pos   (pos[i]),
         .found (found[i])
      );
   end

   assign trial_ok = &found;

   jdm_sequencer #(
      .WIN_W   (WIN_W),
      .GAP_W   (GAP_W),
      .TRIAL_W (TRIAL_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .win_cycles   (win_cycles),
      .gap_cycles   (gap_cycles),
      .trial_target (trial_target),
      .trial_ok     (eval_en && trial_ok),
      .osc_en       (osc_en),
      .capture      (capture),
      .busy         (busy),
      .done         (done),
      .clear_acc    (clear_acc),
      .eval_en      (eval_en),
      .valid_trials (valid_trials)
   );

   jdm_accum #(
      .POS_W (POS_W),
      .SUM_W (SUM_W),
      .SQ_W  (SQ_W)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clear_acc),
      .add    (eval_en && trial_ok),
      .pos_a  (pos[0]),
      .pos_b  (pos[1]),
      .sum    (diff_sum),
      .sq_sum (diff_sq_sum)
   );
endmodule

// File: rtl/jdm_checker.sv
// Temporal checks on the measurement unit's ports.
module jdm_checker #(
   parameter int TRIAL_W = 10,
   parameter int SUM_W   = 15,
   parameter int SQ_W    = 18
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               osc_en,
   input logic               capture,
   input logic               busy,
   input logic               done,
   input logic [TRIAL_W-1:0] valid_trials,
   input logic [SUM_W-1:0]   diff_sum,
   input logic [SQ_W-1:0]    diff_sq_sum
);
   // R2: oscillators only run inside a campaign
   a_r2_en_in_campaign: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en |-> busy);

   // R3: capture directly follows a window, with oscillators stopped
   a_r3_capture_after_window: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> ($past(osc_en) && !osc_en));

   // R8: done is a single-cycle pulse with the unit quiet
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !osc_en && !capture));

   // R9: idle results stay put without a start
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(diff_sum) && $stable(diff_sq_sum) && $stable(valid_trials)));

   // R6: the valid count advances by at most one per cycle during a campaign
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((valid_trials == $past(valid_trials)) ||
                (valid_trials == $past(valid_trials) + TRIAL_W'(1))));

   // R7: the sum of squares never decreases within a campaign
   a_r7_sq_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (diff_sq_sum >= $past(diff_sq_sum)));
endmodule

bind jitter_diff_meter jdm_checker #(
   .TRIAL_W (TRIAL_W),
   .SUM_W   (SUM_W),
   .SQ_W    (SQ_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .osc_en       (osc_en),
   .capture      (capture),
   .busy         (busy),
   .done         (done),
   .valid_trials (valid_trials),
   .diff_sum     (diff_sum),
   .diff_sq_sum  (diff_sq_sum)
);

// File: tb/jitter_diff_meter_test.sv
`timescale 1ns/1ps
module jitter_diff_meter_test;
   localparam int TAP_W   = 16;
   localparam int WIN_W   = 8;
   localparam int GAP_W   = 8;
   localparam int TRIAL_W = 10;
   localparam int POS_W   = $clog2(TAP_W);
   localparam int SUM_W   = POS_W + 1 + TRIAL_W;
   localparam int SQ_W    = 2 * POS_W + TRIAL_W;
   localparam int NPOS    = TAP_W - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [WIN_W-1:0]   win_cycles = '0;
   logic [GAP_W-1:0]   gap_cycles = '0;
   logic [TRIAL_W-1:0] trial_target = '0;
   logic [TAP_W-1:0]   snap_a = '0;
   logic [TAP_W-1:0]   snap_b = '0;
   logic osc_en, capture, busy, done;
   logic [TRIAL_W-1:0]      valid_trials;
   logic signed [SUM_W-1:0] diff_sum;
   logic [SQ_W-1:0]         diff_sq_sum;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   jitter_diff_meter #(
      .TAP_W (TAP_W), .WIN_W (WIN_W), .GAP_W (GAP_W), .TRIAL_W (TRIAL_W)
   ) uut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .win_cycles (win_cycles), .gap_cycles (gap_cycles),
      .trial_target (trial_target), .snap_a (snap_a), .snap_b (snap_b),
      .osc_en (osc_en), .capture (capture), .busy (busy), .done (done),
      .valid_trials (valid_trials), .diff_sum (diff_sum),
      .diff_sq_sum (diff_sq_sum)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Snapshot whose lowest level change is at index p (R5 encoding).
   function automatic logic [TAP_W-1:0] make_snap(input int p, input bit inv, input bit bubble);
      logic [TAP_W-1:0] s = '0;
      for (int j = 0; j < TAP_W; j++) s[j] = (j < p);
      if (bubble && p < TAP_W - 1) s[TAP_W-1] = ~s[TAP_W-1];
      if (inv) s = ~s;
      return s;
   endfunction

   task automatic campaign(input int target, input int win, input int gap,
                           input bit inject_bad, input bit poke, input int seed);
      longint e_sum = 0;
      longint e_sq  = 0;
      int v = seed;
      int k = 0;
      int got = 0;
      int en_run = 0;
      int low_run = 0;
      bit seen_win = 0;
      bit prev_en = 0;
      int wd = 0;
      int exp_win = (win == 0) ? 1 : win;
      int exp_gap = ((gap == 0) ? 1 : gap) + 2;
      longint hold_sum, hold_sq;

      @(negedge clk);
      win_cycles   = WIN_W'(win);
      gap_cycles   = GAP_W'(gap);
      trial_target = TRIAL_W'(target);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      forever begin
         if (osc_en) begin
            if (!prev_en && seen_win) check("R4 idle gap length", low_run, exp_gap);
            en_run++;
         end else begin
            if (prev_en) begin
               check("R2 window length", en_run, exp_win);
               en_run = 0;
               low_run = 1;
               seen_win = 1;
            end else if (seen_win) begin
               low_run++;
            end
         end
         if (capture) begin
            check("R3 capture follows window", {31'd0, prev_en && !osc_en}, 1);
            if (poke && k == 3) start = 1'b1;
            if (inject_bad && (k % 5) == 4) begin
               // R6: flat snapshot on one line
               snap_a = ((k % 10) == 4) ? '0 : make_snap(3, 0, 0);
               snap_b = ((k % 10) == 4) ? make_snap(5, 1, 0) : '1;
            end else begin
               int pa = 1 + (v % NPOS);
               int pb = 1 + ((v / NPOS) % NPOS);
               snap_a = make_snap(pa, v[0], (v % 3) == 0);
               snap_b = make_snap(pb, v[1], (v % 4) == 1);
               e_sum += pa - pb;
               e_sq  += (pa - pb) * (pa - pb);
               got++;
               v++;
            end
            k++;
         end else begin
            start = 1'b0;
         end
         prev_en = osc_en;
         if (done) break;
         wd++;
         if (wd > 20000) begin
            check("watchdog expired", 1, 0);
            break;
         end
         @(negedge clk);
      end
      if (done) begin
         check("R8 busy low at done", busy, 0);
         check("R8 valid count at done", valid_trials, target);
         check("R7 signed sum", diff_sum, e_sum);
         check("R7 square sum", diff_sq_sum, e_sq);
         check("R6 valid trials collected", got, target);
         hold_sum = diff_sum;
         hold_sq  = diff_sq_sum;
         @(negedge clk);
         check("R8 done single cycle", done, 0);
         repeat (5) @(negedge clk);
         check("R9 sum held", diff_sum, hold_sum);
         check("R9 squares held", diff_sq_sum, hold_sq);
         check("R9 count held", valid_trials, target);
         check("R2 oscillators idle", osc_en, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R11 osc_en in reset", osc_en, 0);
      check("R11 done in reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 busy after reset", busy, 0);
      check("R11 capture after reset", capture, 0);
      check("R11 sum after reset", diff_sum, 0);
      check("R11 squares after reset", diff_sq_sum, 0);

      // Full position sweep with bubbles, flat snapshots and a stray start (R1, R5, R6, R7)
      campaign(NPOS * NPOS, 2, 3, 1, 1, 0);
      // Fresh campaign clears results, zero window/gap act as one (R1, R2, R4, R9)
      campaign(20, 0, 0, 0, 0, 7);
      // Longer window, short gap
      campaign(5, 7, 1, 1, 0, 100);

      // R10: zero target
      @(negedge clk);
      trial_target = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10 done after zero-target start", done, 1);
      check("R10 no window", osc_en, 0);
      check("R10 sum cleared", diff_sum, 0);
      check("R10 squares cleared", diff_sq_sum, 0);
      check("R10 count cleared", valid_trials, 0);
      @(negedge clk);
      check("R10 done single", done, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule